// File: doc/BRIEF.md
# Command Status Reply Queue

This block assembles the multi-word status reply that a disk controller hands back to the host once a command finishes. The host then drains the reply one 16-bit word per read strobe. The block builds the leading header word itself from the command code, the device field and the reply length. The two failure replies, for a command the controller does not support and for a command aimed at a drive that is not fitted, are complete nine-word blocks with fixed error codes. The block loads each of these in a single cycle.

For successful information commands, the surrounding logic stages the payload words through a write port and then commits the reply with its length. On every accepted reply the block sets a status-full flag, latches an interrupt status code, and raises a pending interrupt. The interrupt reaches the interrupt line only while the enable input is high. An end-of-interrupt strobe clears the pending state. The queue refuses a new reply while the previous one is still being read or its interrupt is still pending, and it flags each refused attempt.

Top module: `status_resp_queue`

## Requirements
- R1: After reset, status_full_o, irq_pending_o, irq_o and load_err_o are 0, irq_code_o is 0xFF and rd_data_o is 0.
- R2: The header word carries the command code in bits 4:0, the device field in bits 7:5 and the reply length in words (header included) in bits 15:8.
- R3: An accepted failure with fail_absent_i=0 (unsupported command) yields nine words: the header, 0x0F03, 0x0002, then six zero words.
- R4: An accepted failure with fail_absent_i=1 (absent drive) yields nine words: the header, 0x0C11, 0x000B, then six zero words.
- R5: One cycle after an accepted failure, status_full_o and irq_pending_o are 1 and irq_code_o equals {dev_i, 5'h0C}.
- R6: Each word written with ld_we_i is staged after the header, in write order. An accepted ld_commit_i with length ld_len_i publishes the header followed by those words and sets irq_code_o to {dev_i, 5'h01}.
- R7: While the reply is full, rd_data_o shows the next unread word, and each rd_i moves on to the following word. The read of the last word clears status_full_o.
- R8: While status_full_o is 0, rd_data_o is 0, and rd_i changes nothing.
- R9: A failure or commit request made while status_full_o or irq_pending_o is 1 is refused. The reply in progress is left untouched, and load_err_o pulses for one cycle.
- R10: A commit with ld_len_i of 0 or larger than the depth (16) is refused with a load_err_o pulse.
- R11: irq_o equals irq_pending_o AND irq_en_i. An eoi_i strobe clears irq_pending_o on the next cycle.
- R12: ld_we_i while status_full_o is 1 is ignored and does not alter the reply being read.
- R13: When fail_i and ld_commit_i arrive in the same cycle, the failure reply is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_en_i | input | 1 | Interrupt enable |
| fail_i | input | 1 | Request a failure reply |
| fail_absent_i | input | 1 | Failure kind: 0 unsupported command, 1 absent drive |
| cmd_code_i | input | 5 | Command code placed in the header |
| dev_i | input | 3 | Device field for the header and interrupt code |
| ld_we_i | input | 1 | Stage one payload word |
| ld_data_i | input | 16 | Payload word |
| ld_commit_i | input | 1 | Publish the staged reply |
| ld_len_i | input | 5 | Reply length including header |
| rd_i | input | 1 | Read strobe, consumes one word |
| eoi_i | input | 1 | End of interrupt |
| rd_data_o | output | 16 | Current reply word, 0 when empty |
| status_full_o | output | 1 | Reply waiting to be read |
| irq_pending_o | output | 1 | Interrupt pending |
| irq_o | output | 1 | Gated interrupt line |
| irq_code_o | output | 8 | Interrupt status code |
| load_err_o | output | 1 | Refused load, one-cycle pulse |

## Verification
A corrupted read pointer or length shows up on the very next word presented at rd_data_o. A stuck length also shows up as status_full_o clearing one read early or late, or never clearing at all. A wrong busy decision shows up one cycle after the request: either load_err_o stays low and the header on rd_data_o jumps to the new reply mid-drain, or a legal load pulses load_err_o and leaves the queue empty. A bad interrupt code or pending state is visible on irq_code_o and irq_o one cycle after the load or the end-of-interrupt strobe.

// File: rtl/srq_pkg.sv
package srq_pkg;
  localparam int WORD_W   = 16;
  localparam int FAIL_LEN = 9;

  localparam logic [WORD_W-1:0] UNSUP_W1  = 16'h0F03;
  localparam logic [WORD_W-1:0] UNSUP_W2  = 16'h0002;
  localparam logic [WORD_W-1:0] ABSENT_W1 = 16'h0C11;
  localparam logic [WORD_W-1:0] ABSENT_W2 = 16'h000B;

  localparam logic [4:0] IRQ_OK   = 5'h01;
  localparam logic [4:0] IRQ_FAIL = 5'h0C;

  function automatic logic [WORD_W-1:0] make_hdr(input logic [7:0] len,
                                                 input logic [2:0] dev,
                                                 input logic [4:0] code);
    return {len, dev, code};
  endfunction
endpackage

// File: rtl/srq_store.sv
module srq_store #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fill_i,
  input  logic                      fill_absent_i,
  input  logic                      hdr_we_i,
  input  logic [srq_pkg::WORD_W-1:0] hdr_i,
  input  logic                      pay_we_i,
  input  logic [IDX_W-1:0]          pay_idx_i,
  input  logic [srq_pkg::WORD_W-1:0] pay_data_i,
  input  logic [IDX_W-1:0]          rd_idx_i,
  output logic [srq_pkg::WORD_W-1:0] rd_word_o
);
  import srq_pkg::*;

  logic [WORD_W-1:0] mem_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic [WORD_W-1:0] fill_val;
    always_comb begin
      if (i == 0)      fill_val = hdr_i;
      else if (i == 1) fill_val = fill_absent_i ? ABSENT_W1 : UNSUP_W1;
      else if (i == 2) fill_val = fill_absent_i ? ABSENT_W2 : UNSUP_W2;
      else             fill_val = '0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mem_q[i] <= '0;
      end else if (fill_i) begin
        mem_q[i] <= fill_val;
      end else if (hdr_we_i && i == 0) begin
        mem_q[i] <= hdr_i;
      end else if (pay_we_i && pay_idx_i == IDX_W'(i)) begin
        mem_q[i] <= pay_data_i;
      end
    end
  end

  assign rd_word_o = mem_q[rd_idx_i];
endmodule

// File: rtl/srq_reader.sv
module srq_reader #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             rd_i,
  output logic             full_o,
  output logic [IDX_W-1:0] ptr_o
);
  logic             full_q;
  logic [IDX_W-1:0] ptr_q;
  logic [LEN_W-1:0] len_q;
  logic             last;

  assign last = (LEN_W'(ptr_q) + LEN_W'(1)) == len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      ptr_q  <= '0;
      len_q  <= '0;
    end else if (load_i) begin
      full_q <= 1'b1;
      ptr_q  <= '0;
      len_q  <= len_i;
    end else if (rd_i && full_q) begin
      if (last) begin
        full_q <= 1'b0;
        ptr_q  <= '0;
        len_q  <= '0;
      end else begin
        ptr_q  <= ptr_q + IDX_W'(1);
      end
    end
  end

  assign full_o = full_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/srq_irq.sv
module srq_irq (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       set_i,
  input  logic [7:0] code_i,
  input  logic       eoi_i,
  input  logic       irq_en_i,
  output logic       pending_o,
  output logic [7:0] code_o,
  output logic       irq_o
);
  logic       pend_q;
  logic [7:0] code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      code_q <= 8'hFF;
    end else if (set_i) begin
      pend_q <= 1'b1;
      code_q <= code_i;
    end else if (eoi_i) begin
      pend_q <= 1'b0;
    end
  end

  assign pending_o = pend_q;
  assign code_o    = code_q;
  assign irq_o     = pend_q & irq_en_i;
endmodule

// File: rtl/status_resp_queue.sv
module status_resp_queue #(
  parameter int DEPTH = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int LEN_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             irq_en_i,
  input  logic             fail_i,
  input  logic             fail_absent_i,
  input  logic [4:0]       cmd_code_i,
  input  logic [2:0]       dev_i,
  input  logic             ld_we_i,
  input  logic [15:0]      ld_data_i,
  input  logic             ld_commit_i,
  input  logic [LEN_W-1:0] ld_len_i,
  input  logic             rd_i,
  input  logic             eoi_i,
  output logic [15:0]      rd_data_o,
  output logic             status_full_o,
  output logic             irq_pending_o,
  output logic             irq_o,
  output logic [7:0]       irq_code_o,
  output logic             load_err_o
);
  import srq_pkg::*;

  logic             full, pending, busy, len_ok;
  logic             fail_go, cmt_go, load_go, err_d, err_q;
  logic [LEN_W-1:0] load_len;
  logic [7:0]       irq_code_d;
  logic [WORD_W-1:0] hdr, word;
  logic [LEN_W-1:0] stg_q;
  logic             stg_we;
  logic [IDX_W-1:0] rd_ptr;

  assign busy    = full | pending;
  assign len_ok  = (ld_len_i != '0) && (ld_len_i <= LEN_W'(DEPTH));
  assign fail_go = fail_i & ~busy;
  assign cmt_go  = ld_commit_i & ~fail_i & ~busy & len_ok;
  assign load_go = fail_go | cmt_go;
  assign err_d   = (fail_i & busy) | (ld_commit_i & ~fail_i & (busy | ~len_ok));

  assign load_len   = fail_go ? LEN_W'(FAIL_LEN) : ld_len_i;
  assign hdr        = make_hdr(8'(load_len), dev_i, cmd_code_i);
  assign irq_code_d = {dev_i, fail_go ? IRQ_FAIL : IRQ_OK};

  // staging pointer: payload slots start right after the header
  assign stg_we = ld_we_i & ~full & ~load_go & (stg_q < LEN_W'(DEPTH));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= LEN_W'(1);
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
      if (load_go)     stg_q <= LEN_W'(1);
      else if (stg_we) stg_q <= stg_q + LEN_W'(1);
    end
  end

  srq_store #(.DEPTH(DEPTH)) u_store (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fill_i        (fail_go),
    .fill_absent_i (fail_absent_i),
    .hdr_we_i      (cmt_go),
    .hdr_i         (hdr),
    .pay_we_i      (stg_we),
    .pay_idx_i     (IDX_W'(stg_q)),
    .pay_data_i    (ld_data_i),
    .rd_idx_i      (rd_ptr),
    .rd_word_o     (word)
  );

  srq_reader #(.DEPTH(DEPTH)) u_reader (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_go),
    .len_i  (load_len),
    .rd_i   (rd_i),
    .full_o (full),
    .ptr_o  (rd_ptr)
  );

  srq_irq u_irq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (load_go),
    .code_i    (irq_code_d),
    .eoi_i     (eoi_i),
    .irq_en_i  (irq_en_i),
    .pending_o (pending),
    .code_o    (irq_code_o),
    .irq_o     (irq_o)
  );

  assign rd_data_o     = full ? word : '0;
  assign status_full_o = full;
  assign irq_pending_o = pending;
  assign load_err_o    = err_q;
endmodule

// File: rtl/srq_checker.sv
module srq_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        irq_en_i,
  input logic        fail_i,
  input logic        ld_commit_i,
  input logic        rd_i,
  input logic        eoi_i,
  input logic [15:0] rd_data_o,
  input logic        status_full_o,
  input logic        irq_pending_o,
  input logic        irq_o,
  input logic [7:0]  irq_code_o,
  input logic        load_err_o
);
  assert_empty_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_full_o |-> rd_data_o == 16'h0);

  assert_irq_gate_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (irq_en_i && irq_pending_o));

  assert_eoi_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && irq_pending_o) |=> !irq_pending_o);

  assert_reject_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((fail_i || ld_commit_i) && (status_full_o || irq_pending_o)) |=> load_err_o);

  assert_fail_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_i && !status_full_o && !irq_pending_o)
      |=> (status_full_o && irq_pending_o && irq_code_o[4:0] == 5'h0C));

  assert_drain_by_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_full_o) |-> $past(rd_i));

  assert_hold_while_full_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_full_o && !rd_i) |=> (status_full_o && $stable(rd_data_o)));
endmodule

bind status_resp_queue srq_checker u_srq_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .irq_en_i      (irq_en_i),
  .fail_i        (fail_i),
  .ld_commit_i   (ld_commit_i),
  .rd_i          (rd_i),
  .eoi_i         (eoi_i),
  .rd_data_o     (rd_data_o),
  .status_full_o (status_full_o),
  .irq_pending_o (irq_pending_o),
  .irq_o         (irq_o),
  .irq_code_o    (irq_code_o),
  .load_err_o    (load_err_o)
);

// File: tb/status_resp_queue_test.sv
module status_resp_queue_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        irq_en_i = 1'b1;
  logic        fail_i = 1'b0, fail_absent_i = 1'b0;
  logic [4:0]  cmd_code_i = '0;
  logic [2:0]  dev_i = '0;
  logic        ld_we_i = 1'b0;
  logic [15:0] ld_data_i = '0;
  logic        ld_commit_i = 1'b0;
  logic [4:0]  ld_len_i = '0;
  logic        rd_i = 1'b0, eoi_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        status_full_o, irq_pending_o, irq_o, load_err_o;
  logic [7:0]  irq_code_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  status_resp_queue uut (.*);

  // {absent, dev, code, word1, word2, irq code}
  localparam logic [48:0] VEC [4] = '{
    {1'b0, 3'd7, 5'h0A, 16'h0F03, 16'h0002, 8'hEC},
    {1'b1, 3'd0, 5'h01, 16'h0C11, 16'h000B, 8'h0C},
    {1'b1, 3'd1, 5'h05, 16'h0C11, 16'h000B, 8'h2C},
    {1'b0, 3'd1, 5'h1F, 16'h0F03, 16'h0002, 8'h2C}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic read_word(input string req, input logic [15:0] exp);
    chk(req, rd_data_o, exp);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic eoi();
    eoi_i = 1'b1;
    @(negedge clk_i);
    eoi_i = 1'b0;
  endtask

  task automatic fail_req(input logic absent, input logic [2:0] dev, input logic [4:0] code);
    fail_i = 1'b1; fail_absent_i = absent; dev_i = dev; cmd_code_i = code;
    @(negedge clk_i);
    fail_i = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    // R1 reset state
    chk("R1 full", 16'(status_full_o), 16'h0);
    chk("R1 pending", 16'(irq_pending_o), 16'h0);
    chk("R1 irq", 16'(irq_o), 16'h0);
    chk("R1 code", 16'(irq_code_o), 16'h00FF);
    chk("R1 data", rd_data_o, 16'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 code after release", 16'(irq_code_o), 16'h00FF);

    // table of failure replies: R2 R3 R4 R5 R7
    for (int v = 0; v < 4; v++) begin
      fail_req(VEC[v][48], VEC[v][47:45], VEC[v][44:40]);
      chk("R5 full", 16'(status_full_o), 16'h1);
      chk("R5 pending", 16'(irq_pending_o), 16'h1);
      chk("R5 code", 16'(irq_code_o), 16'(VEC[v][7:0]));
      read_word("R2 header", {8'd9, VEC[v][47:45], VEC[v][44:40]});
      read_word(VEC[v][48] ? "R4 word1" : "R3 word1", VEC[v][39:24]);
      read_word(VEC[v][48] ? "R4 word2" : "R3 word2", VEC[v][23:8]);
      for (int k = 3; k < 9; k++) begin
        chk("R7 still full", 16'(status_full_o), 16'h1);
        read_word(VEC[v][48] ? "R4 zero" : "R3 zero", 16'h0);
      end
      chk("R7 drained", 16'(status_full_o), 16'h0);
      eoi();
      chk("R11 eoi clears", 16'(irq_pending_o), 16'h0);
    end

    // R6 generic load
    ld_we_i = 1'b1; ld_data_i = 16'hA001; @(negedge clk_i);
    ld_data_i = 16'hB002; @(negedge clk_i);
    ld_data_i = 16'hC003; @(negedge clk_i);
    ld_we_i = 1'b0;
    ld_commit_i = 1'b1; ld_len_i = 5'd4; dev_i = 3'd7; cmd_code_i = 5'h0A;
    @(negedge clk_i);
    ld_commit_i = 1'b0;
    chk("R6 code", 16'(irq_code_o), 16'h00E1);
    chk("R11 irq on", 16'(irq_o), 16'h1);
    irq_en_i = 1'b0; #1;
    chk("R11 irq gated", 16'(irq_o), 16'h0);
    irq_en_i = 1'b1;
    read_word("R6 header", 16'h04EA);
    // R12 payload write while full ignored
    ld_we_i = 1'b1; ld_data_i = 16'hDEAD; @(negedge clk_i);
    ld_we_i = 1'b0;
    read_word("R12 word1 intact", 16'hA001);
    // R9 fail while full refused
    fail_req(1'b1, 3'd0, 5'h01);
    chk("R9 err pulse", 16'(load_err_o), 16'h1);
    @(negedge clk_i);
    chk("R9 err one cycle", 16'(load_err_o), 16'h0);
    read_word("R9 word2 intact", 16'hB002);
    read_word("R6 word3", 16'hC003);
    chk("R7 drained generic", 16'(status_full_o), 16'h0);
    // R8 read when empty
    read_word("R8 empty read", 16'h0);
    chk("R8 still empty", 16'(status_full_o), 16'h0);
    // R9 commit while only pending
    ld_commit_i = 1'b1; ld_len_i = 5'd1;
    @(negedge clk_i);
    ld_commit_i = 1'b0;
    chk("R9 pending refuse err", 16'(load_err_o), 16'h1);
    chk("R9 pending refuse full", 16'(status_full_o), 16'h0);
    eoi();

    // R10 bad lengths
    ld_commit_i = 1'b1; ld_len_i = 5'd0;
    @(negedge clk_i);
    chk("R10 len0 err", 16'(load_err_o), 16'h1);
    chk("R10 len0 empty", 16'(status_full_o), 16'h0);
    ld_len_i = 5'd17;
    @(negedge clk_i);
    ld_commit_i = 1'b0;
    chk("R10 len17 err", 16'(load_err_o), 16'h1);
    chk("R10 len17 empty", 16'(status_full_o), 16'h0);

    // R13 fail wins over commit
    fail_i = 1'b1; fail_absent_i = 1'b0; ld_commit_i = 1'b1; ld_len_i = 5'd2;
    dev_i = 3'd2; cmd_code_i = 5'h03;
    @(negedge clk_i);
    fail_i = 1'b0; ld_commit_i = 1'b0;
    chk("R13 no err", 16'(load_err_o), 16'h0);
    chk("R13 code", 16'(irq_code_o), 16'h004C);
    read_word("R13 header", 16'h0943);
    read_word("R13 word1", 16'h0F03);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule